// File: doc/BRIEF.md
# Lookup-Table Activation Unit

This unit applies a fixed nonlinearity, either the logistic sigmoid or the hyperbolic tangent, to a signed fixed-point sample. It does no arithmetic on the function itself. The function is evaluated at elaboration time at the centre of every bin of a configurable input window, and the quantised values are held in a read-only table. At run time the unit only clamps the input to the window, turns it into a bin number and reads the table. One sample per clock goes in with a valid strobe. The result comes out with a matching strobe after a fixed delay of two cycles.

The unit sits behind a neuron accumulator stage. The input format uses the same parameters as the layer outputs: a total width and an integer width that counts the sign bit. The window bounds `RANGE_LO` and `RANGE_HI` are whole numbers. The parameters also set the number of bins and the output width. `USE_TANH` chooses the function. The tanh result is signed and the sigmoid result is unsigned.

Top module: `act_table_unit`

## Requirements
- R1: While `rst` is high and on the first edge after it, `outValid` is 0 and `dataOut` is all zeros.
- R2: A sample presented with `inValid` high at edge k gives `outValid` high after edge k+2. Samples may arrive on consecutive cycles, and results leave in the same order, one per cycle.
- R3: For a raw input x, where x is the value times 2^(IN_W−IN_INT), the bin is floor((x − RANGE_LO·2^F)·BINS / ((RANGE_HI − RANGE_LO)·2^F)). This holds whenever that offset lies in [0, span).
- R4: An input below `RANGE_LO` uses bin 0. An input exactly at `RANGE_LO` also uses bin 0.
- R5: An input at or above `RANGE_HI` uses bin BINS−1. Nothing wraps.
- R6: With `USE_TANH`=0, entry i is floor(σ(c_i)·2^OUT_W), saturated to 2^OUT_W−1, and is read as an unsigned fraction. Here c_i = RANGE_LO + (i+0.5)·(RANGE_HI−RANGE_LO)/BINS.
- R7: With `USE_TANH`=1, entry i is tanh(c_i)·2^(OUT_W−1) truncated toward zero and saturated to ±(2^(OUT_W−1)−1). It is read as two's complement, so the most negative code never appears.
- R8: Over any ascending sequence of inputs, the results never decrease. Sigmoid results are compared unsigned and tanh results are compared signed.
- R9: While `inValid` is low, `dataIn` is ignored. `dataOut` keeps the last result and `outValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `dataIn` as a sample this cycle |
| dataIn | input | IN_W | Signed fixed-point sample, IN_INT integer bits including the sign |
| outValid | output | 1 | Marks `dataOut` as a new result |
| dataOut | output | OUT_W | Table value: an unsigned fraction for sigmoid, a signed fraction for tanh |

## Verification
The in-module properties assume that `inValid` is 0 or 1 on every clock edge and that `dataIn` is a defined value whenever `inValid` is high. They also assume that reset is held long enough for both pipeline stages to clear. The bench meets these assumptions: it drives every input on the falling edge, holds reset for several cycles, and keeps `dataIn` defined at all times. It drives the same stimulus into a sigmoid instance and a tanh instance, including values beyond both ends of the 16-bit window and exactly on both bounds.

// File: rtl/act_table_pkg.sv
package act_table_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadIdx;   // capture bin index of the incoming sample
    logic loadOut;   // capture the table word for the staged index
  } actStrobes_t;

endpackage

// File: rtl/act_table_ctrl.sv
module act_table_ctrl
  import act_table_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output actStrobes_t strobes,
  output logic        outValid
);

  logic idxValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      idxValid <= inValid;
      outValid <= idxValid;
    end
  end

  always_comb begin
    strobes.loadIdx = inValid;
    strobes.loadOut = idxValid;
  end

  // R2: each stage's valid follows the previous stage by one edge
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(idxValid)) && (idxValid == $past(inValid)));

endmodule

// File: rtl/act_table_datapath.sv
module act_table_datapath
  import act_table_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_INT   = 6,
  parameter int RANGE_LO = -8,
  parameter int RANGE_HI = 8,
  parameter int BINS     = 64,
  parameter int OUT_W    = 10,
  parameter bit USE_TANH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  actStrobes_t       strobes,
  input  logic [IN_W-1:0]   dataIn,
  output logic [OUT_W-1:0]  dataOut
);

  localparam int     FRAC_W   = IN_W - IN_INT;
  localparam int     IDX_W    = (BINS > 1) ? $clog2(BINS) : 1;
  localparam int     OFF_W    = IN_W + 14;
  localparam int     PROD_W   = OFF_W + IDX_W + 1;
  localparam longint LO_RAW   = longint'(RANGE_LO) * (longint'(1) << FRAC_W);
  localparam longint SPAN_RAW = longint'(RANGE_HI - RANGE_LO) * (longint'(1) << FRAC_W);
  localparam int     MAX_CODE = USE_TANH ? ((1 << (OUT_W - 1)) - 1) : ((1 << OUT_W) - 1);

  // Quantised function value at the centre of bin idx.
  function automatic logic [OUT_W-1:0] lutValue(input int idx);
    real binW;
    real centre;
    real ex;
    real y;
    int  q;
    binW   = real'(RANGE_HI - RANGE_LO) / real'(BINS);
    centre = real'(RANGE_LO) + (real'(idx) + 0.5) * binW;
    if (USE_TANH) begin
      ex = $exp(2.0 * centre);
      y  = (ex - 1.0) / (ex + 1.0);
      q  = $rtoi(y * (2.0 ** (OUT_W - 1)));
      if (q > MAX_CODE)  q = MAX_CODE;
      if (q < -MAX_CODE) q = -MAX_CODE;
    end else begin
      y = 1.0 / (1.0 + $exp(-centre));
      q = $rtoi(y * (2.0 ** OUT_W));
      if (q > MAX_CODE) q = MAX_CODE;
      if (q < 0)        q = 0;
    end
    return OUT_W'(q);
  endfunction

  logic [OUT_W-1:0] romTable [BINS];

  for (genvar g = 0; g < BINS; g++) begin : g_rom
    localparam logic [OUT_W-1:0] ENTRY = lutValue(g);
    assign romTable[g] = ENTRY;
  end

  logic signed [OFF_W-1:0] inWide;
  logic signed [OFF_W-1:0] offset;
  logic [IDX_W-1:0]        idxNext;
  logic [IDX_W-1:0]        idxReg;
  logic [OUT_W-1:0]        outReg;

  assign inWide = OFF_W'($signed(dataIn));
  assign offset = inWide - OFF_W'(LO_RAW);

  // Clamp to the window and scale the offset into a bin number.
  always_comb begin
    if (offset < 0) begin
      idxNext = '0;
    end else if (offset >= OFF_W'(SPAN_RAW)) begin
      idxNext = IDX_W'(BINS - 1);
    end else begin
      idxNext = IDX_W'((PROD_W'(offset) * PROD_W'(BINS)) / PROD_W'(SPAN_RAW));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg <= '0;
      outReg <= '0;
    end else begin
      if (strobes.loadIdx) idxReg <= idxNext;
      if (strobes.loadOut) outReg <= romTable[idxReg];
    end
  end

  assign dataOut = outReg;

  // Ordering view of the output: signed for tanh, unsigned for sigmoid.
  logic signed [OUT_W:0] outOrd;
  if (USE_TANH) begin : g_ord_signed
    assign outOrd = (OUT_W+1)'($signed(outReg));
  end else begin : g_ord_unsigned
    assign outOrd = $signed({1'b0, outReg});
  end

  a_r4_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadIdx && (inWide < OFF_W'(LO_RAW))) |=> (idxReg == '0));

  a_r5_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadIdx && (inWide >= OFF_W'(LO_RAW + SPAN_RAW))) |=> (idxReg == IDX_W'(BINS - 1)));

  a_r8_monotonic: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && strobes.loadOut && $past(strobes.loadOut) && (idxReg >= $past(idxReg)))
      |=> (outOrd >= $past(outOrd)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !strobes.loadOut) |=> $stable(outReg));

  if (USE_TANH) begin : g_tanh_chk
    a_r7_no_min_code: assert property (@(posedge clk) disable iff (rst)
      outReg != {1'b1, {(OUT_W-1){1'b0}}});
  end

endmodule

// File: rtl/act_table_unit.sv
module act_table_unit
  import act_table_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int IN_INT   = 6,
  parameter int RANGE_LO = -8,
  parameter int RANGE_HI = 8,
  parameter int BINS     = 64,
  parameter int OUT_W    = 10,
  parameter bit USE_TANH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  dataIn,
  output logic             outValid,
  output logic [OUT_W-1:0] dataOut
);

  actStrobes_t strobes;

  act_table_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  act_table_datapath #(
    .IN_W     (IN_W),
    .IN_INT   (IN_INT),
    .RANGE_LO (RANGE_LO),
    .RANGE_HI (RANGE_HI),
    .BINS     (BINS),
    .OUT_W    (OUT_W),
    .USE_TANH (USE_TANH)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/act_table_unit_tb_top.sv
`timescale 1ns/1ps
module act_table_unit_tb_top;

  localparam int IN_W = 16, IN_INT = 6, RLO = -8, RHI = 8, BINS = 64, OUT_W = 10;
  localparam int FRAC = IN_W - IN_INT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [IN_W-1:0] dataIn = '0;
  logic sigValid, tanValid;
  logic [OUT_W-1:0] sigOut, tanOut;

  always #2.5 clk = ~clk;

  act_table_unit #(.IN_W(IN_W), .IN_INT(IN_INT), .RANGE_LO(RLO), .RANGE_HI(RHI),
                   .BINS(BINS), .OUT_W(OUT_W), .USE_TANH(1'b0)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .outValid(sigValid), .dataOut(sigOut));

  act_table_unit #(.IN_W(IN_W), .IN_INT(IN_INT), .RANGE_LO(RLO), .RANGE_HI(RHI),
                   .BINS(BINS), .OUT_W(OUT_W), .USE_TANH(1'b1)) dut_tanh_i (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .outValid(tanValid), .dataOut(tanOut));

  typedef struct {
    int    sigExp;
    int    tanExp;
    int    dueCycle;
    bit    mono;
    string tag;
  } item_t;

  item_t sb[$];
  int nChecks = 0, nFails = 0, cycle = 0;
  int lastSig = 0, lastTan = 0;
  bit done = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic int refIndex(int x);
    longint off, span;
    off  = longint'(x) - longint'(RLO) * (longint'(1) << FRAC);
    span = longint'(RHI - RLO) * (longint'(1) << FRAC);
    if (off < 0) return 0;
    if (off >= span) return BINS - 1;
    return int'((off * BINS) / span);
  endfunction

  // Signed integer value of the expected table entry.
  function automatic int refValue(int idx, bit tanh);
    real c, e, y;
    int q, lim;
    c = real'(RLO) + (real'(idx) + 0.5) * real'(RHI - RLO) / real'(BINS);
    if (tanh) begin
      lim = (1 << (OUT_W - 1)) - 1;
      e = $exp(2.0 * c);
      y = (e - 1.0) / (e + 1.0);
      q = $rtoi(y * (2.0 ** (OUT_W - 1)));
      if (q > lim) q = lim;
      if (q < -lim) q = -lim;
    end else begin
      lim = (1 << OUT_W) - 1;
      y = 1.0 / (1.0 + $exp(-c));
      q = $rtoi(y * (2.0 ** OUT_W));
      if (q > lim) q = lim;
      if (q < 0) q = 0;
    end
    return q;
  endfunction

  function automatic int asSigned(logic [OUT_W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(int x, bit mono, string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = IN_W'(x);
    it.sigExp   = refValue(refIndex(x), 1'b0);
    it.tanExp   = refValue(refIndex(x), 1'b1);
    it.dueCycle = cycle + 2;
    it.mono     = mono;
    it.tag      = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      dataIn  = IN_W'(16'h5A5A + i * 977);
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst && (sigValid || tanValid)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected result", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(sigValid && tanValid && cycle == it.dueCycle, "R2", "result cycle", cycle, it.dueCycle);
        check(int'(sigOut) == it.sigExp, it.tag, "sigmoid value", int'(sigOut), it.sigExp);
        check(asSigned(tanOut) == it.tanExp, it.tag, "tanh value", asSigned(tanOut), it.tanExp);
        if (it.mono) begin
          check(int'(sigOut) >= lastSig, "R8", "sigmoid order", int'(sigOut), lastSig);
          check(asSigned(tanOut) >= lastTan, "R8", "tanh order", asSigned(tanOut), lastTan);
        end
        lastSig = int'(sigOut);
        lastTan = asSigned(tanOut);
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(!sigValid && !tanValid, "R1", "valid in reset", int'(sigValid), 0);
    check(sigOut == '0 && tanOut == '0, "R1", "data in reset", int'(sigOut), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sigValid && sigOut == '0, "R1", "after reset", int'(sigOut), 0);

    // R4: below the window and on its lower bound
    drive(-32768, 1'b0, "R4");
    drive(-8193, 1'b0, "R4");
    drive(-8192, 1'b0, "R4");
    // R5: on and above the upper bound, last bin just inside
    drive(8191, 1'b0, "R5");
    drive(8192, 1'b0, "R5");
    drive(32767, 1'b0, "R5");
    // R3: bin edges in the middle
    drive(0, 1'b0, "R3");
    drive(-1, 1'b0, "R3");
    drive(255, 1'b0, "R3");
    drive(256, 1'b0, "R3");
    idle(4);

    // R6, R7, R8: back-to-back ascending sweep past both bounds
    drive(-9000, 1'b0, "R6");
    for (int x = -9000 + 97; x <= 9000; x += 97) drive(x, 1'b1, "R7");
    idle(6);

    // R9: dataIn toggles while inValid low; output held
    begin
      logic [OUT_W-1:0] hs, ht;
      hs = sigOut; ht = tanOut;
      idle(5);
      check(!sigValid && !tanValid, "R9", "valid while idle", int'(sigValid), 0);
      check(sigOut == hs && tanOut == ht, "R9", "held data", int'(sigOut), int'(hs));
      check(int'(sigOut) == refValue(BINS - 1, 1'b0), "R9", "held last value", int'(sigOut),
            refValue(BINS - 1, 1'b0));
    end
    check(sb.size() == 0, "R2", "pending results", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule